// File: doc/BRIEF.md
# Banked Hashed History Dictionary

This block holds the recent history of a multi-byte-per-cycle LZ77 compressor. Each accepted cycle it takes a window of VEC new bytes plus the VEC-1 bytes after them. From these it forms VEC overlapping substrings, each VEC bytes long. Substring p starts at window byte p.

Every substring is hashed to an address. That address is read in all VEC banks, so each substring position gets VEC candidate earlier substrings. Each candidate comes with the absolute stream position at which it was stored. In the same cycle, substring p is written into bank p at its own hash address.

A downstream stage compares the bytes of the candidates against the current substrings. It computes a match offset as the current position minus the candidate's stored position. That stage is not part of this block.

Top module: `lzd_history_dict`

## Requirements
- R1: A synchronous reset marks every entry of every bank empty. In the first cycle after reset, `out_valid` and every `out_cand_hit` bit are 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock.
- R3: Candidate slot p*VEC+b shows the entry that bank b held at the hash address of substring p.
  - `out_cand_hit` is 1 when that entry was filled.
  - `out_cand_str` then carries the stored VEC bytes, and `out_cand_pos` carries the stored stream position.
  - An empty entry gives hit 0, with its string and position fields reading as zero.
- R4: A lookup sees the banks as they were before the same cycle's writes. An identical substring written in the same cycle is not reported.
- R5: When `in_valid` is 1, substring p is written only into bank p, at its hash address. It is stored with stream position `in_pos + p` (modulo 2^POS_W).
- R6: When `in_valid` is 0, no bank entry changes. A later lookup therefore cannot return bytes from that window.
- R7: The hash of a substring is formed in two steps.
  - First a raw value is made from its first HB bytes: the XOR of byte k shifted left by 2k bits, for k from 0 to HB-1.
  - Then raw bit j is XORed into address bit (j mod AW).
- R8: One cycle after an accepted window, `out_pos` repeats `in_pos`. `out_cur_str` repeats the VEC substrings, with substring p at bits [p*VEC*8 +: VEC*8] and its byte 0 in the low bits.
- R9: Window byte k of `in_bytes` sits at bits [8k+7:8k], and byte 0 is the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window accepted this cycle |
| in_bytes | input | (2*VEC-1)*8 | Window bytes, byte 0 in the low bits |
| in_pos | input | POS_W | Stream position of window byte 0 |
| out_valid | output | 1 | Lookup result valid |
| out_pos | output | POS_W | Position of the window being reported |
| out_cur_str | output | VEC*VEC*8 | The current substrings |
| out_cand_hit | output | VEC*VEC | Candidate filled, slot p*VEC+b |
| out_cand_str | output | VEC*VEC*VEC*8 | Candidate bytes, slot p*VEC+b |
| out_cand_pos | output | VEC*VEC*POS_W | Candidate stored positions, slot p*VEC+b |

## Verification
A wrong internal state shows at the ports only when a later window hashes to the corrupted address. The effect is then one of three things: a missing candidate, an extra candidate, or a wrong stored position. It appears one cycle after that later window is presented.

The bench therefore keeps a full model of every bank and re-reads addresses it has written before. It does this after invalid windows, after same-cycle collisions and after a reset. An address written while it should not have been, or a stale valid flag, then surfaces in the very next lookup that touches it.

// File: rtl/lzd_pkg.sv
package lzd_pkg;
  // width of the raw hash value before folding to the address width
  function automatic int raw_hash_w(input int hb);
    return 8 + 2 * (hb - 1);
  endfunction
endpackage

// File: rtl/lzd_hash.sv
module lzd_hash #(
  parameter int HB = 3,
  parameter int AW = 5
) (
  input  logic [HB*8-1:0] key,
  output logic [AW-1:0]   addr
);
  localparam int RW = lzd_pkg::raw_hash_w(HB);

  logic [RW-1:0] raw;

  always_comb begin
    raw = '0;
    for (int k = 0; k < HB; k++) begin
      raw = raw ^ (RW'(key[k*8 +: 8]) << (2 * k));
    end
  end

  always_comb begin
    addr = '0;
    for (int j = 0; j < RW; j++) begin
      addr[j % AW] = addr[j % AW] ^ raw[j];
    end
  end
endmodule

// File: rtl/lzd_bank.sv
module lzd_bank #(
  parameter int AW  = 5,
  parameter int EW  = 48,
  parameter int NRD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [EW-1:0]     wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*EW-1:0] rdata,
  output logic [NRD-1:0]    rhit
);
  localparam int DEPTH = 1 << AW;

  logic [EW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] filled;

  // data array: no reset so it can map onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    for (int r = 0; r < NRD; r++) begin
      rdata[r*EW +: EW] <= mem[raddr[r*AW +: AW]];
    end
  end

  // fill flags live in flops so that reset can clear them at once
  always_ff @(posedge clk) begin
    if (rst) begin
      filled <= '0;
      rhit   <= '0;
    end else begin
      if (we) filled[waddr] <= 1'b1;
      for (int r = 0; r < NRD; r++) begin
        rhit[r] <= filled[raddr[r*AW +: AW]];
      end
    end
  end
endmodule

// File: rtl/lzd_history_dict.sv
module lzd_history_dict #(
  parameter int VEC   = 4,
  parameter int AW    = 5,
  parameter int POS_W = 16,
  parameter int HB    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [(2*VEC-1)*8-1:0]     in_bytes,
  input  logic [POS_W-1:0]           in_pos,
  output logic                       out_valid,
  output logic [POS_W-1:0]           out_pos,
  output logic [VEC*VEC*8-1:0]       out_cur_str,
  output logic [VEC*VEC-1:0]         out_cand_hit,
  output logic [VEC*VEC*VEC*8-1:0]   out_cand_str,
  output logic [VEC*VEC*POS_W-1:0]   out_cand_pos
);
  localparam int SW = VEC * 8;
  localparam int EW = SW + POS_W;
  localparam int NS = VEC * VEC;

  logic [VEC*SW-1:0] sub;
  logic [VEC*AW-1:0] haddr;
  logic [NS*EW-1:0]  cand_raw;
  logic [NS-1:0]     cand_hit;

  // overlapping substrings and their hash addresses
  for (genvar p = 0; p < VEC; p++) begin : g_pos
    assign sub[p*SW +: SW] = in_bytes[p*8 +: SW];
    lzd_hash #(.HB(HB), .AW(AW)) hash_i (
      .key  (in_bytes[p*8 +: HB*8]),
      .addr (haddr[p*AW +: AW])
    );
  end

  // bank b: one write port fed by position b, read by every position
  for (genvar b = 0; b < VEC; b++) begin : g_bank
    logic [VEC*EW-1:0] rd;
    logic [VEC-1:0]    rh;
    logic [POS_W-1:0]  wpos;
    assign wpos = in_pos + POS_W'(b);

    lzd_bank #(.AW(AW), .EW(EW), .NRD(VEC)) bank_i (
      .clk   (clk),
      .rst   (rst),
      .we    (in_valid),
      .waddr (haddr[b*AW +: AW]),
      .wdata ({wpos, sub[b*SW +: SW]}),
      .raddr (haddr),
      .rdata (rd),
      .rhit  (rh)
    );

    for (genvar p = 0; p < VEC; p++) begin : g_rd
      assign cand_raw[(p*VEC+b)*EW +: EW] = rd[p*EW +: EW];
      assign cand_hit[p*VEC+b]            = rh[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    out_pos     <= in_pos;
    out_cur_str <= sub;
  end

  // empty entries read as zero
  for (genvar s = 0; s < NS; s++) begin : g_out
    assign out_cand_hit[s]             = cand_hit[s];
    assign out_cand_str[s*SW +: SW]    = cand_hit[s] ? cand_raw[s*EW +: SW] : '0;
    assign out_cand_pos[s*POS_W +: POS_W] =
      cand_hit[s] ? cand_raw[s*EW+SW +: POS_W] : '0;
  end
endmodule

// File: rtl/lzd_history_dict_chk.sv
module lzd_history_dict_chk #(
  parameter int VEC   = 4,
  parameter int AW    = 5,
  parameter int POS_W = 16,
  parameter int HB    = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [POS_W-1:0]         in_pos,
  input logic                     out_valid,
  input logic [POS_W-1:0]         out_pos,
  input logic [VEC*VEC*8-1:0]     out_cur_str,
  input logic [VEC*VEC-1:0]       out_cand_hit,
  input logic [VEC*VEC*VEC*8-1:0] out_cand_str
);
  localparam int SW = VEC * 8;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r8_pos_echo: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_pos == $past(in_pos));
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_cand_hit == '0);

  // a filled candidate was stored at the address its own bytes hash to
  for (genvar p = 0; p < VEC; p++) begin : g_p
    logic [AW-1:0] h_cur;
    lzd_hash #(.HB(HB), .AW(AW)) hc_i (
      .key (out_cur_str[p*SW +: HB*8]), .addr (h_cur));
    for (genvar b = 0; b < VEC; b++) begin : g_b
      logic [AW-1:0] h_cand;
      lzd_hash #(.HB(HB), .AW(AW)) hk_i (
        .key (out_cand_str[(p*VEC+b)*SW +: HB*8]), .addr (h_cand));
      a_r3_r7_hash_agrees: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_cand_hit[p*VEC+b] |-> h_cand == h_cur);
    end
  end
endmodule

bind lzd_history_dict lzd_history_dict_chk #(
  .VEC(VEC), .AW(AW), .POS_W(POS_W), .HB(HB)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_pos       (in_pos),
  .out_valid    (out_valid),
  .out_pos      (out_pos),
  .out_cur_str  (out_cur_str),
  .out_cand_hit (out_cand_hit),
  .out_cand_str (out_cand_str)
);

// File: tb/lzd_history_dict_tb_top.sv
module lzd_history_dict_tb_top;
  localparam int VEC   = 4;
  localparam int AW    = 5;
  localparam int POS_W = 16;
  localparam int HB    = 3;
  localparam int NB    = 2 * VEC - 1;
  localparam int SW    = VEC * 8;
  localparam int DEPTH = 1 << AW;
  localparam int NV    = 12;
  localparam int VW    = 1 + POS_W + NB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NB*8-1:0] in_bytes = '0;
  logic [POS_W-1:0] in_pos = '0;
  logic out_valid;
  logic [POS_W-1:0] out_pos;
  logic [VEC*VEC*8-1:0] out_cur_str;
  logic [VEC*VEC-1:0] out_cand_hit;
  logic [VEC*VEC*SW-1:0] out_cand_str;
  logic [VEC*VEC*POS_W-1:0] out_cand_pos;

  always #5 clk = ~clk;

  lzd_history_dict #(.VEC(VEC), .AW(AW), .POS_W(POS_W), .HB(HB)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes),
    .in_pos(in_pos), .out_valid(out_valid), .out_pos(out_pos),
    .out_cur_str(out_cur_str), .out_cand_hit(out_cand_hit),
    .out_cand_str(out_cand_str), .out_cand_pos(out_cand_pos));

  // {valid, position, seven text bytes written oldest first}
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b1, 16'd0,  "textsam"},   // R1 empty history
    {1'b1, 16'd4,  "textsam"},   // R3 R5 repeat hits own banks
    {1'b0, 16'd8,  "xyzxyzx"},   // R2 R6 not accepted
    {1'b1, 16'd12, "xyzxyzx"},   // R6 nothing stored from previous
    {1'b1, 16'd16, "aaaaaaa"},   // R4 same-cycle equal substrings
    {1'b1, 16'd20, "aaaaaaa"},   // R4 R5 now visible in every bank
    {1'b1, 16'd24, "aaaabbb"},   // R7 shared prefix
    {1'b1, 16'd28, "textsam"},   // R5 positions of older copy
    {1'b1, 16'd32, "qrstuvw"},
    {1'b0, 16'd36, "aaaaaaa"},   // R6 overwrite blocked
    {1'b1, 16'd40, "samtext"},
    {1'b1, 16'hFFFE, "aaaabbb"}  // R5 position wraps
  };

  logic [SW-1:0]    m_str [VEC][DEPTH];
  logic [POS_W-1:0] m_pos [VEC][DEPTH];
  logic             m_val [VEC][DEPTH];

  logic [VEC*VEC-1:0]       e_hit;
  logic [VEC*VEC*SW-1:0]    e_str;
  logic [VEC*VEC*POS_W-1:0] e_pos;
  logic [VEC*VEC*8-1:0]     e_cur;

  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [AW-1:0] ref_hash(input logic [SW-1:0] s);
    logic [AW-1:0] a = '0;
    int raw = 0;
    for (int k = 0; k < HB; k++) raw = raw ^ (int'(s[k*8 +: 8]) << (2 * k));
    for (int j = 0; j < 8 + 2 * (HB - 1); j++) a[j % AW] = a[j % AW] ^ raw[j];
    return a;
  endfunction

  function automatic string vtag(input int i);
    case (i)
      0: return "R1";
      2, 3, 9: return "R6";
      4, 5: return "R4";
      6: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int b = 0; b < VEC; b++)
      for (int a = 0; a < DEPTH; a++) m_val[b][a] = 1'b0;
  endtask

  // drive one window at a falling edge, model the banks, check at the next falling edge
  task automatic apply(input bit v, input logic [POS_W-1:0] pos,
                       input logic [NB*8-1:0] bytes_lsb, input string tag);
    logic [SW-1:0] s;
    logic [AW-1:0] a;
    in_valid = v; in_bytes = bytes_lsb; in_pos = pos;
    for (int p = 0; p < VEC; p++) begin
      s = bytes_lsb[p*8 +: SW];
      e_cur[p*SW +: SW] = s;
      a = ref_hash(s);
      for (int b = 0; b < VEC; b++) begin
        e_hit[p*VEC+b] = m_val[b][a];
        e_str[(p*VEC+b)*SW +: SW] = m_val[b][a] ? m_str[b][a] : '0;
        e_pos[(p*VEC+b)*POS_W +: POS_W] = m_val[b][a] ? m_pos[b][a] : '0;
      end
    end
    if (v) begin
      for (int b = 0; b < VEC; b++) begin
        s = bytes_lsb[b*8 +: SW];
        a = ref_hash(s);
        m_val[b][a] = 1'b1; m_str[b][a] = s; m_pos[b][a] = pos + POS_W'(b);
      end
    end
    @(negedge clk);
    chk(out_valid == v, "R2", "out_valid", 128'(out_valid), 128'(v));
    if (v) begin
      chk(out_pos == pos, "R8", "out_pos", 128'(out_pos), 128'(pos));
      chk(out_cur_str == e_cur, "R8 R9", "out_cur_str", 128'(out_cur_str), 128'(e_cur));
      chk(out_cand_hit == e_hit, tag, "cand_hit R3 R7", 128'(out_cand_hit), 128'(e_hit));
      chk(out_cand_str == e_str, tag, "cand_str R3", 128'(out_cand_str), 128'(e_str));
      chk(out_cand_pos == e_pos, tag, "cand_pos R5", 128'(out_cand_pos), 128'(e_pos));
    end
  endtask

  function automatic logic [NB*8-1:0] to_lsb(input logic [NB*8-1:0] lit);
    logic [NB*8-1:0] r;
    for (int k = 0; k < NB; k++) r[k*8 +: 8] = lit[8*(NB-1-k) +: 8];
    return r;
  endfunction

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 0);
    chk(out_cand_hit == '0, "R1", "hits after reset", 128'(out_cand_hit), 0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][VW-1], VECS[i][NB*8 +: POS_W], to_lsb(VECS[i][NB*8-1:0]), vtag(i));
    end

    // R1: reset in the middle of a stream forgets everything
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_model();
    @(negedge clk);
    chk(out_cand_hit == '0, "R1", "hits after mid reset", 128'(out_cand_hit), 0);
    apply(1'b1, 16'd100, to_lsb("textsam"), "R1");
    apply(1'b1, 16'd104, to_lsb("textsam"), "R5");
    // R4: back-to-back identical window, no idle cycle between
    apply(1'b1, 16'd108, to_lsb("zzzzzzz"), "R4");
    apply(1'b1, 16'd109, to_lsb("zzzzzzz"), "R4");
    in_valid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule